// File: doc/BRIEF.md
# SPI Master Shift Engine

This block runs one full-duplex serial transfer in SPI master fashion each time it is started. A parallel word is loaded together with a set of transfer options: the level SCK rests at, which of two clocking formats to use, whether the least or the most significant bit leads, and whether the word is 8 or 16 bits long. The engine then lowers its active-low select line, toggles SCK at a rate set by a divider off the system clock, shifts the word out on MOSI and gathers the word coming back on MISO.

The received word is copied into a separate output register only after its final bit has arrived. A completion flag is raised at the same moment. The output register therefore keeps showing the previous result while the next transfer runs. Software-side logic clears the flag with a one-cycle acknowledge strobe. The engine accepts a new start only when it is idle, so the options can be changed between words to talk to slaves with different needs.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset, `ss_n_o` is 1 and `busy_o`, `done_o` and `rx_word_o` are 0. While idle, `sck_o` follows `pol_i` with one cycle of delay, so SCK rests low for `pol_i`=0 and high for `pol_i`=1.
- R2: `start_i` is taken only in a cycle where `busy_o` is 0. On acceptance, `tx_word_i` and all option inputs are captured. A `start_i` pulse seen while busy has no effect on the running word, and no second transfer follows it.
- R3: One SCK half-period lasts `div_i`+1 system clocks (call this H). The first SCK edge comes H clocks after `ss_n_o` goes low, in both formats.
- R4: A transfer of n bits makes exactly 2n SCK edges. n is 8 when `wide_i`=0 and 16 when `wide_i`=1. After the last edge, SCK is back at its idle level.
- R5: With `pha_i`=0, the first outgoing bit is on `mosi_o` in the cycle `ss_n_o` falls. MISO is latched on odd-numbered edges. The latched bit enters the shift register on the next even edge, and `mosi_o` moves to the next bit there (a moment when SCK is at its idle level).
- R6: With `pha_i`=1, `mosi_o` changes only on odd-numbered edges (SCK away from its idle level). MISO is sampled and shifted in on even-numbered edges.
- R7: With `lsb_first_i`=0, bit n-1 of the word leaves first and received bits enter at bit 0. With `lsb_first_i`=1, bit 0 leaves first and received bits enter at bit n-1. Either way, the received word holds the slave's word in its natural bit order.
- R8: `rx_word_o` changes only in the cycle of the 2n-th edge. In 8-bit mode, bits 15..8 read as 0.
- R9: `done_o` rises in the cycle of the 2n-th edge and is cleared by `rd_ack_i`. If a completion and an acknowledge fall in the same cycle, the flag ends up set.
- R10: `ss_n_o` returns high H clocks after the final edge, so it stays low for (2n+1)·H clocks in total. `busy_o` falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a transfer when idle |
| tx_word_i | input | 16 | Word to send (low byte used in 8-bit mode) |
| pol_i | input | 1 | SCK idle level |
| pha_i | input | 1 | Clocking format select (0: data valid before first edge) |
| lsb_first_i | input | 1 | 1 sends bit 0 first |
| wide_i | input | 1 | 1 for 16-bit words, 0 for 8-bit words |
| div_i | input | 8 | SCK half-period minus one, in system clocks |
| rd_ack_i | input | 1 | Clears the completion flag |
| miso_i | input | 1 | Serial data from the slave |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| ss_n_o | output | 1 | Active-low slave select |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Completion flag |
| rx_word_o | output | 16 | Last received word |

## Verification
Two events can land in the same clock: setting the completion flag at the final SCK edge, and an acknowledge strobe clearing it. The bench counts cycles from the accepted start and pulses `rd_ack_i` exactly in the cycle of edge 2n. It then expects `done_o` to read 1 afterwards, along with a correct `rx_word_o`. A second clash, a start request arriving mid-transfer, is provoked by pulsing `start_i` with a different word while busy. That case is judged by the word a behavioural slave captured and by counting falls of `ss_n_o`.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

   // engine sequencing: select asserted lead-in is part of SHIFT, TAIL is the
   // trailing half-period before select is released
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SHIFT = 2'd1,
      PH_TAIL  = 2'd2
   } phase_e;

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   output logic             tick
);

   logic [CNT_W-1:0] cnt_q;

   assign tick = run && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + CNT_W'(1);
   end

endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
   parameter int WORD_W   = 16,
   parameter int NARROW_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              pha,
   input  logic              lsb_first,
   input  logic              wide,
   input  logic              odd_edge,
   input  logic              even_edge,
   input  logic              last_edge,
   input  logic              miso,
   output logic              mosi,
   output logic [WORD_W-1:0] shifted
);

   localparam int IDX_W = $clog2(WORD_W);

   logic [WORD_W-1:0] sreg_q;
   logic              held_q;
   logic [IDX_W-1:0]  top_idx;
   logic              in_bit;

   assign top_idx = wide ? IDX_W'(WORD_W - 1) : IDX_W'(NARROW_W - 1);
   // phase 1 samples on the shifting edge itself, phase 0 uses the held bit
   assign in_bit  = pha ? miso : held_q;

   function automatic logic tap(input logic [WORD_W-1:0] w, input logic lsb,
                                input logic [IDX_W-1:0] ti);
      return lsb ? w[0] : w[ti];
   endfunction

   always_comb begin
      if (lsb_first) begin
         shifted          = sreg_q >> 1;
         shifted[top_idx] = in_bit;
      end else begin
         shifted = {sreg_q[WORD_W-2:0], in_bit};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg_q <= '0;
         held_q <= 1'b0;
         mosi   <= 1'b0;
      end else if (load) begin
         sreg_q <= tx_word;
         mosi   <= tap(tx_word, lsb_first, top_idx);
      end else if (odd_edge) begin
         if (pha)
            mosi <= tap(sreg_q, lsb_first, top_idx);
         else
            held_q <= miso;
      end else if (even_edge) begin
         sreg_q <= shifted;
         if (!pha && !last_edge)
            mosi <= tap(shifted, lsb_first, top_idx);
      end
   end

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
   import spi_xfer_pkg::*;
#(
   parameter int WORD_W   = 16,
   parameter int NARROW_W = 8,
   parameter int DIV_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [WORD_W-1:0] tx_word_i,
   input  logic              pol_i,
   input  logic              pha_i,
   input  logic              lsb_first_i,
   input  logic              wide_i,
   input  logic [DIV_W-1:0]  div_i,
   input  logic              rd_ack_i,
   input  logic              miso_i,
   output logic              sck_o,
   output logic              mosi_o,
   output logic              ss_n_o,
   output logic              busy_o,
   output logic              done_o,
   output logic [WORD_W-1:0] rx_word_o
);

   localparam int EDGE_W = $clog2(2 * WORD_W);

   if (NARROW_W < 2 || NARROW_W >= WORD_W) begin : g_bad_width
      $error("spi_xfer_engine: NARROW_W must lie in [2, WORD_W)");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("spi_xfer_engine: DIV_W must be at least 1");
   end

   phase_e             st_q;
   logic               cfg_pol, cfg_pha, cfg_lsb, cfg_wide;
   logic [DIV_W-1:0]   cfg_div;
   logic [EDGE_W-1:0]  edge_q;
   logic [EDGE_W-1:0]  last_cnt;
   logic               sck_q, ss_q, done_q;
   logic [WORD_W-1:0]  rx_q;
   logic [WORD_W-1:0]  rx_mask;
   logic [WORD_W-1:0]  shifted;
   logic               accept, tick, shift_tick, odd_edge, even_edge, last_even;
   logic               eff_pha, eff_lsb, eff_wide;

   assign accept     = start_i && (st_q == PH_IDLE);
   assign shift_tick = tick && (st_q == PH_SHIFT);
   assign odd_edge   = shift_tick && !edge_q[0];
   assign even_edge  = shift_tick &&  edge_q[0];
   assign last_cnt   = cfg_wide ? EDGE_W'(2 * WORD_W - 1) : EDGE_W'(2 * NARROW_W - 1);
   assign last_even  = even_edge && (edge_q == last_cnt);

   // options reach the shifter live on the load cycle, latched afterwards
   assign eff_pha  = accept ? pha_i       : cfg_pha;
   assign eff_lsb  = accept ? lsb_first_i : cfg_lsb;
   assign eff_wide = accept ? wide_i      : cfg_wide;

   for (genvar g = 0; g < WORD_W; g++) begin : g_mask
      if (g < NARROW_W) begin : g_low
         assign rx_mask[g] = 1'b1;
      end else begin : g_high
         assign rx_mask[g] = cfg_wide;
      end
   end

   spi_half_timer #(
      .CNT_W (DIV_W)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (st_q != PH_IDLE),
      .limit (cfg_div),
      .tick  (tick)
   );

   spi_bit_shifter #(
      .WORD_W   (WORD_W),
      .NARROW_W (NARROW_W)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .tx_word   (tx_word_i),
      .pha       (eff_pha),
      .lsb_first (eff_lsb),
      .wide      (eff_wide),
      .odd_edge  (odd_edge),
      .even_edge (even_edge),
      .last_edge (last_even),
      .miso      (miso_i),
      .mosi      (mosi_o),
      .shifted   (shifted)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= PH_IDLE;
         cfg_pol  <= 1'b0;
         cfg_pha  <= 1'b0;
         cfg_lsb  <= 1'b0;
         cfg_wide <= 1'b0;
         cfg_div  <= '0;
         edge_q   <= '0;
         sck_q    <= 1'b0;
         ss_q     <= 1'b1;
      end else begin
         case (st_q)
            PH_IDLE: begin
               sck_q <= pol_i;
               if (accept) begin
                  st_q     <= PH_SHIFT;
                  cfg_pol  <= pol_i;
                  cfg_pha  <= pha_i;
                  cfg_lsb  <= lsb_first_i;
                  cfg_wide <= wide_i;
                  cfg_div  <= div_i;
                  edge_q   <= '0;
                  ss_q     <= 1'b0;
               end
            end
            PH_SHIFT: begin
               if (tick) begin
                  sck_q  <= ~sck_q;
                  edge_q <= edge_q + EDGE_W'(1);
                  if (edge_q == last_cnt)
                     st_q <= PH_TAIL;
               end
            end
            PH_TAIL: begin
               if (tick) begin
                  ss_q <= 1'b1;
                  st_q <= PH_IDLE;
               end
            end
            default: st_q <= PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         rx_q   <= '0;
      end else begin
         if (last_even) begin
            done_q <= 1'b1;
            rx_q   <= shifted & rx_mask;
         end else if (rd_ack_i) begin
            done_q <= 1'b0;
         end
      end
   end

   assign sck_o     = sck_q;
   assign ss_n_o    = ss_q;
   assign busy_o    = (st_q != PH_IDLE);
   assign done_o    = done_q;
   assign rx_word_o = rx_q;

endmodule

// File: rtl/spi_xfer_checker.sv
module spi_xfer_checker #(
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pol_i,
   input logic              busy_o,
   input logic              ss_n_o,
   input logic              sck_o,
   input logic              mosi_o,
   input logic              done_o,
   input logic [WORD_W-1:0] rx_word_o,
   input logic              cfg_pol,
   input logic              cfg_pha
);

   // R1
   idle_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && $past(!busy_o) && $past(rst_n)) |-> (sck_o == $past(pol_i)));

   // R10
   select_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !ss_n_o);

   // R8
   rx_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_word_o) |-> (done_o && busy_o));

   // R9
   done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> (busy_o && sck_o == cfg_pol));

   // R5
   pha0_mosi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o) && !cfg_pha && !$stable(mosi_o)) |-> (sck_o == cfg_pol));

   // R6
   pha1_mosi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o) && cfg_pha && !$stable(mosi_o)) |-> (sck_o != cfg_pol));

endmodule

bind spi_xfer_engine spi_xfer_checker #(
   .WORD_W (WORD_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pol_i     (pol_i),
   .busy_o    (busy_o),
   .ss_n_o    (ss_n_o),
   .sck_o     (sck_o),
   .mosi_o    (mosi_o),
   .done_o    (done_o),
   .rx_word_o (rx_word_o),
   .cfg_pol   (cfg_pol),
   .cfg_pha   (cfg_pha)
);

// File: tb/spi_xfer_engine_tb.sv
module spi_xfer_engine_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] tx_word = '0;
   logic        pol = 1'b0, pha = 1'b0, lsb = 1'b0, wide = 1'b0;
   logic [7:0]  div = '0;
   logic        rd_ack = 1'b0;
   logic        miso = 1'b0;
   logic        sck, mosi, ss_n, busy, done;
   logic [15:0] rx_word;

   int n_chk = 0, n_fail = 0, cyc = 0;

   // behavioural slave state
   logic        t_pha = 1'b0, t_lsb = 1'b0;
   logic [15:0] t_sw = '0;
   int          t_n = 8;
   logic        prev_sck = 1'b0, prev_ss = 1'b1;
   int          ecount = 0, fall_cyc = 0, first_cyc = 0, rise_cyc = 0, n_falls = 0;
   logic [15:0] cap_word = '0;
   logic        first_mosi = 1'b0;

   always #4 clk = ~clk;

   spi_xfer_engine u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .tx_word_i   (tx_word),
      .pol_i       (pol),
      .pha_i       (pha),
      .lsb_first_i (lsb),
      .wide_i      (wide),
      .div_i       (div),
      .rd_ack_i    (rd_ack),
      .miso_i      (miso),
      .sck_o       (sck),
      .mosi_o      (mosi),
      .ss_n_o      (ss_n),
      .busy_o      (busy),
      .done_o      (done),
      .rx_word_o   (rx_word)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, 150000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   function automatic logic sbit(input int k);
      return t_lsb ? t_sw[k] : t_sw[t_n - 1 - k];
   endfunction

   task automatic store(input int k);
      if (t_lsb) cap_word[k] = mosi;
      else       cap_word[t_n - 1 - k] = mosi;
   endtask

   always @(negedge clk) begin
      if (prev_ss && !ss_n) begin
         ecount = 0; fall_cyc = cyc; cap_word = '0; first_mosi = mosi; n_falls++;
         if (!t_pha) miso = sbit(0);
      end else if (!ss_n && sck != prev_sck) begin
         ecount++;
         if (ecount == 1) first_cyc = cyc;
         if (ecount % 2 == 1) begin
            if (!t_pha) store((ecount - 1) / 2);
            else        miso = sbit((ecount - 1) / 2);
         end else begin
            if (t_pha) store(ecount / 2 - 1);
            else if (ecount / 2 < t_n) miso = sbit(ecount / 2);
         end
      end
      if (!prev_ss && ss_n) rise_cyc = cyc;
      prev_sck = sck;
      prev_ss  = ss_n;
   end

   task automatic check(input logic ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp_v);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp_v);
      end
   endtask

   task automatic setup(input logic p, ph, l, w, input int d,
                        input logic [15:0] tx, sw);
      @(negedge clk);
      pol = p; pha = ph; lsb = l; wide = w; div = 8'(d); tx_word = tx;
      t_pha = ph; t_lsb = l; t_sw = sw; t_n = w ? 16 : 8;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic pulse_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_end();
      do @(negedge clk); while (!ss_n);
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic judge(input logic p, ph, l, input int d, input logic [15:0] tx, sw);
      int h = d + 1;
      logic [15:0] m = (t_n == 16) ? 16'hFFFF : 16'h00FF;
      check(first_cyc - fall_cyc == h, "R3 lead half-period", first_cyc - fall_cyc, h);
      check(ecount == 2 * t_n, "R4 edge count", ecount, 2 * t_n);
      check(sck == p, "R4 sck back to idle", sck, p);
      check(rise_cyc - fall_cyc == (2 * t_n + 1) * h, "R10 select low time",
            rise_cyc - fall_cyc, (2 * t_n + 1) * h);
      check(busy == 1'b0, "R10 busy low after select", busy, 0);
      check(cap_word == (tx & m), "R7 bits seen by slave", cap_word, tx & m);
      check(rx_word == (sw & m), "R7/R8 received word", rx_word, sw & m);
      if (!ph)
         check(first_mosi == (l ? tx[0] : tx[t_n - 1]), "R5 first bit at select",
               first_mosi, l ? tx[0] : tx[t_n - 1]);
      check(done == 1'b1, "R9 flag set", done, 1);
   endtask

   task automatic ack();
      rd_ack = 1'b1;
      @(negedge clk);
      rd_ack = 1'b0;
      check(done == 1'b0, "R9 flag cleared by ack", done, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(ss_n == 1'b1, "R1 reset select", ss_n, 1);
      check(busy == 1'b0, "R1 reset busy", busy, 0);
      check(done == 1'b0, "R1 reset flag", done, 0);
      check(rx_word == 16'h0, "R1 reset rx word", rx_word, 0);

      // sweep of all formats, orders, widths and three divider values
      for (int idx = 0; idx < 48; idx++) begin
         logic p  = idx[0];
         logic ph = idx[1];
         logic l  = idx[2];
         logic w  = idx[3];
         int   d  = (idx / 16 == 0) ? 0 : (idx / 16 == 1) ? 1 : 3;
         logic [15:0] tx = 16'hA5C3 ^ 16'(idx * 16'h1357);
         logic [15:0] sw = 16'h3C96 + 16'(idx * 16'h0F1D);
         setup(p, ph, l, w, d, tx, sw);
         check(sck == p, "R1 idle sck level", sck, p);
         pulse_start();
         wait_end();
         judge(p, ph, l, d, tx, sw);
         ack();
      end

      // R2 and R8: start while busy is ignored, rx holds old word meanwhile
      begin
         logic [15:0] old_rx;
         int falls0;
         setup(1'b0, 1'b1, 1'b0, 1'b1, 2, 16'h9E37, 16'h4D21);
         old_rx = rx_word;
         falls0 = n_falls;
         pulse_start();
         repeat (20) @(negedge clk);
         tx_word = 16'h1111;
         pulse_start();
         repeat (20) @(negedge clk);
         check(rx_word == old_rx, "R8 rx held during transfer", rx_word, old_rx);
         check(done == 1'b0, "R9 flag low during transfer", done, 0);
         wait_end();
         judge(1'b0, 1'b1, 1'b0, 2, 16'h9E37, 16'h4D21);
         repeat (30) @(negedge clk);
         check(n_falls == falls0 + 1, "R2 no second transfer", n_falls, falls0 + 1);
         check(ss_n == 1'b1, "R2 select stays high", ss_n, 1);
         ack();
      end

      // R9: acknowledge in the very cycle of the final edge
      setup(1'b1, 1'b0, 1'b1, 1'b0, 1, 16'h00C5, 16'h005A);
      pulse_start();
      repeat (31) @(negedge clk);
      rd_ack = 1'b1;
      @(negedge clk);
      rd_ack = 1'b0;
      check(done == 1'b1, "R9 set wins over ack", done, 1);
      check(rx_word == 16'h005A, "R8 word at final edge", rx_word, 16'h005A);
      wait_end();
      ack();

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule